// File: doc/BRIEF.md
# Conversion Card Sequencer for an Eight-Input Multiplexed ADC

This block is the control logic of one conversion card that shares a parallel bus with other cards. Each bus address carries a card field above a three-bit channel field. When the card field equals the card's static address, the card accepts the request, sets the analog multiplexer to the requested channel, waits a settling time, pulses start-convert to the converter, and copies the finished code into a data latch after a fixed conversion time.

Reads are pipelined. An accepted request puts the word latched by the *previous* conversion on the bus and starts a new one. The requester therefore sees each channel's result one access later. The latch holds the 14-bit two's-complement code left-justified in a 16-bit word, with the unused low bits at zero.

After reset the card first waits out the converter's self-calibration time. Two conversions never start closer together than one throughput period. A request that cannot be served at once is held, and a wait output stays high until the request is served.

Top module: `madc_card_seq`

## Requirements
- R1: A request is accepted only when bus_addr[5:3] equals card_addr. Any other request leaves bus_oe low, leaves bus_wait low, starts no conversion and leaves the latch unchanged.
- R2: An accepted request raises bus_oe for exactly one cycle. That cycle is the first cycle after the request is served, and in it bus_rdata carries the latch contents from before this request's conversion.
- R3: mux_sel takes bus_addr[2:0] when the request is served and holds that value through the settling time and the conversion.
- R4: adc_start is a one-cycle pulse that comes SETTLE_CYC cycles after the bus_oe cycle of the same request.
- R5: CONV_CYC cycles after adc_start, the latch loads adc_data shifted left by two bits (code in bits 15:2, bits 1:0 zero). The next served request returns this word.
- R6: Two adc_start pulses are at least THRU_CYC cycles apart. A request held back by this limit is served exactly THRU_CYC cycles after the previous adc_start.
- R7: No conversion starts before calibration ends. A request made during calibration is served in cycle CAL_CYC+1 after reset is released.
- R8: A matching request that cannot be served at once raises bus_wait from the next cycle. bus_wait falls in the cycle where bus_oe rises. A further request made while one is pending is ignored.
- R9: During and after reset, bus_oe, bus_wait and adc_start are low, mux_sel is 0, and the latch reads zero until the first conversion completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter-domain clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| card_addr | input | 3 | Static address of this card |
| bus_req | input | 1 | One-cycle request strobe from the bus |
| bus_addr | input | 6 | Card field (5:3) and channel field (2:0) |
| bus_rdata | output | 16 | Returned word, zero when bus_oe is low |
| bus_oe | output | 1 | Output enable for bus_rdata; low models tri-state |
| bus_wait | output | 1 | A request is held and not yet served |
| mux_sel | output | 3 | Analog multiplexer select |
| adc_start | output | 1 | Start-convert pulse to the converter |
| adc_data | input | 14 | Converter result, valid at the end of conversion |

## Verification
If the card is idle, bus_oe follows in the first cycle after the request edge and adc_start follows SETTLE_CYC cycles later. The captured code is seen only at the next served request. A request held behind a conversion gets its bus_oe exactly THRU_CYC cycles after the previous adc_start. A request made during calibration gets its bus_oe in cycle CAL_CYC+1. The bench samples on falling edges and counts rising edges since reset was released. It compares each event's cycle number with these sums, and it compares each returned word with a value computed from the bench's own code formula, applied to the channel and conversion index of the previous served request.

// File: rtl/madc_seq_pkg.sv
package madc_seq_pkg;

  typedef enum logic [1:0] {
    ST_CAL    = 2'd0,
    ST_IDLE   = 2'd1,
    ST_SETTLE = 2'd2,
    ST_CONV   = 2'd3
  } seq_state_t;

  // A request may be served only while idle and after the throughput window has closed.
  function automatic logic can_serve(input seq_state_t st, input logic thru_zero);
    return (st == ST_IDLE) && thru_zero;
  endfunction

endpackage

// File: rtl/madc_addr_decode.sv
module madc_addr_decode #(
  parameter int CARD_W = 3,
  parameter int CHAN_W = 3
) (
  input  logic                     bus_req,
  input  logic [CARD_W+CHAN_W-1:0] bus_addr,
  input  logic [CARD_W-1:0]        card_addr,
  output logic                     hit,
  output logic [CHAN_W-1:0]        chan
);

  logic [CARD_W-1:0] card_field;

  assign card_field = bus_addr[CARD_W+CHAN_W-1:CHAN_W];
  assign chan       = bus_addr[CHAN_W-1:0];
  assign hit        = bus_req && (card_field == card_addr);

endmodule

// File: rtl/madc_down_timer.sv
module madc_down_timer #(
  parameter int W       = 8,
  parameter int RST_VAL = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= W'(RST_VAL);
    else if (load)     cnt_q <= load_val;
    else if (!zero)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/madc_card_seq.sv
module madc_card_seq #(
  parameter int CARD_W     = 3,
  parameter int CHAN_W     = 3,
  parameter int RES_W      = 14,
  parameter int WORD_W     = 16,
  parameter int CAL_CYC    = 3000,
  parameter int SETTLE_CYC = 8,
  parameter int CONV_CYC   = 57,
  parameter int THRU_CYC   = 190
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [CARD_W-1:0]        card_addr,
  input  logic                     bus_req,
  input  logic [CARD_W+CHAN_W-1:0] bus_addr,
  output logic [WORD_W-1:0]        bus_rdata,
  output logic                     bus_oe,
  output logic                     bus_wait,
  output logic [CHAN_W-1:0]        mux_sel,
  output logic                     adc_start,
  input  logic [RES_W-1:0]         adc_data
);
  import madc_seq_pkg::*;

  localparam int STEP_MAX = (CAL_CYC > CONV_CYC)
                            ? ((CAL_CYC > SETTLE_CYC) ? CAL_CYC : SETTLE_CYC)
                            : ((CONV_CYC > SETTLE_CYC) ? CONV_CYC : SETTLE_CYC);
  localparam int STEP_W   = $clog2(STEP_MAX + 1);
  localparam int THRU_W   = $clog2(THRU_CYC + 1);
  localparam int PAD_W    = WORD_W - RES_W;

  // Left-justify the converter code; unused low bits forced to zero.
  function automatic logic [WORD_W-1:0] left_justify(input logic [RES_W-1:0] code);
    return {code, {PAD_W{1'b0}}};
  endfunction

  seq_state_t          state_q, state_d;
  logic                hit;
  logic [CHAN_W-1:0]   hit_chan;
  logic                pend_q;
  logic [CHAN_W-1:0]   pend_chan_q;
  logic [CHAN_W-1:0]   mux_q;
  logic [WORD_W-1:0]   latch_q;
  logic [WORD_W-1:0]   rdata_q;
  logic                oe_q;
  logic                start_q;

  logic                step_load, step_zero;
  logic [STEP_W-1:0]   step_val;
  logic                thru_load, thru_zero;

  // Named internal events, also used by the bound checker.
  logic                ready;
  logic                svc;
  logic [CHAN_W-1:0]   svc_chan;
  logic                fire;
  logic                capture;
  logic                cal_done;
  logic                conv_busy;

  madc_addr_decode #(.CARD_W(CARD_W), .CHAN_W(CHAN_W)) u_dec (
    .bus_req   (bus_req),
    .bus_addr  (bus_addr),
    .card_addr (card_addr),
    .hit       (hit),
    .chan      (hit_chan)
  );

  // Shared step timer: calibration after reset, then settling and conversion.
  madc_down_timer #(.W(STEP_W), .RST_VAL(CAL_CYC - 1)) u_step (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (step_load),
    .load_val (step_val),
    .zero     (step_zero)
  );

  // Throughput window, opened at every start-convert.
  madc_down_timer #(.W(THRU_W), .RST_VAL(0)) u_thru (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (thru_load),
    .load_val (THRU_W'(THRU_CYC - 1)),
    .zero     (thru_zero)
  );

  assign ready     = can_serve(state_q, thru_zero);
  assign svc       = ready && (pend_q || hit);
  assign svc_chan  = pend_q ? pend_chan_q : hit_chan;
  assign cal_done  = (state_q != ST_CAL);
  assign conv_busy = (state_q == ST_SETTLE) || (state_q == ST_CONV);

  always_comb begin
    state_d   = state_q;
    step_load = 1'b0;
    step_val  = '0;
    thru_load = 1'b0;
    fire      = 1'b0;
    capture   = 1'b0;
    case (state_q)
      ST_CAL: begin
        if (step_zero) state_d = ST_IDLE;
      end
      ST_IDLE: begin
        if (svc) begin
          state_d   = ST_SETTLE;
          step_load = 1'b1;
          step_val  = STEP_W'(SETTLE_CYC - 1);
        end
      end
      ST_SETTLE: begin
        if (step_zero) begin
          state_d   = ST_CONV;
          step_load = 1'b1;
          step_val  = STEP_W'(CONV_CYC - 1);
          thru_load = 1'b1;
          fire      = 1'b1;
        end
      end
      ST_CONV: begin
        if (step_zero) begin
          state_d = ST_IDLE;
          capture = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_CAL;
      pend_q      <= 1'b0;
      pend_chan_q <= '0;
      mux_q       <= '0;
      latch_q     <= '0;
      rdata_q     <= '0;
      oe_q        <= 1'b0;
      start_q     <= 1'b0;
    end else begin
      state_q <= state_d;
      start_q <= fire;
      oe_q    <= svc;
      rdata_q <= svc ? latch_q : '0;
      if (svc) mux_q <= svc_chan;
      if (capture) latch_q <= left_justify(adc_data);
      if (svc) begin
        pend_q <= 1'b0;
      end else if (hit && !pend_q) begin
        pend_q      <= 1'b1;
        pend_chan_q <= hit_chan;
      end
    end
  end

  assign bus_rdata = rdata_q;
  assign bus_oe    = oe_q;
  assign bus_wait  = pend_q;
  assign mux_sel   = mux_q;
  assign adc_start = start_q;

endmodule

// File: rtl/madc_card_seq_chk.sv
module madc_card_seq_chk #(
  parameter int CHAN_W   = 3,
  parameter int WORD_W   = 16,
  parameter int PAD_W    = 2,
  parameter int THRU_CYC = 190
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_oe,
  input logic              bus_wait,
  input logic [WORD_W-1:0] bus_rdata,
  input logic              adc_start,
  input logic [CHAN_W-1:0] mux_sel,
  input logic              cal_done,
  input logic              conv_busy
);

  localparam int GAP_W = $clog2(THRU_CYC + 1);

  logic [GAP_W-1:0] gap_q;
  logic             seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (adc_start) begin
      gap_q  <= '0;
      seen_q <= 1'b1;
    end else if (gap_q != GAP_W'(THRU_CYC)) begin
      gap_q <= gap_q + 1'b1;
    end
  end

  a_r2_oe_single: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |=> !bus_oe);

  a_r3_mux_held: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_busy && $past(conv_busy)) |-> $stable(mux_sel));

  a_r4_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |=> !adc_start);

  a_r5_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> (bus_rdata[PAD_W-1:0] == '0));

  a_r6_start_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_start && seen_q) |-> (gap_q >= GAP_W'(THRU_CYC - 1)));

  a_r7_no_start_in_cal: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |-> cal_done);

  a_r8_wait_excl_oe: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wait && bus_oe));

endmodule

bind madc_card_seq madc_card_seq_chk #(
  .CHAN_W   (CHAN_W),
  .WORD_W   (WORD_W),
  .PAD_W    (WORD_W - RES_W),
  .THRU_CYC (THRU_CYC)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_oe    (bus_oe),
  .bus_wait  (bus_wait),
  .bus_rdata (bus_rdata),
  .adc_start (adc_start),
  .mux_sel   (mux_sel),
  .cal_done  (cal_done),
  .conv_busy (conv_busy)
);

// File: tb/madc_card_seq_test.sv
module madc_card_seq_test;

  localparam int CAL  = 20;
  localparam int SET  = 3;
  localparam int CONV = 57;
  localparam int THRU = 80;
  localparam logic [2:0] CARD = 3'd5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  card_addr = CARD;
  logic        bus_req = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [15:0] bus_rdata;
  logic        bus_oe, bus_wait, adc_start;
  logic [2:0]  mux_sel;
  logic [13:0] adc_data = '0;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  int nstub = 0;
  int n_oe  = 0;
  int n_start = 0;
  logic [15:0] prev = '0;
  int nserved = 0;
  int last_start = 0;

  always #2 clk = ~clk;

  madc_card_seq #(
    .CAL_CYC(CAL), .SETTLE_CYC(SET), .CONV_CYC(CONV), .THRU_CYC(THRU)
  ) uut (
    .clk(clk), .rst_n(rst_n), .card_addr(card_addr), .bus_req(bus_req),
    .bus_addr(bus_addr), .bus_rdata(bus_rdata), .bus_oe(bus_oe),
    .bus_wait(bus_wait), .mux_sel(mux_sel), .adc_start(adc_start),
    .adc_data(adc_data)
  );

  function automatic int code_of(input int ch, input int k);
    return (ch * 1511 + k * 389 + 123) % 16384;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  // Converter stub: presents the code shortly after start, well before capture.
  always @(posedge clk) begin
    if (rst_n && adc_start) begin
      adc_data <= 14'(code_of(int'(mux_sel), nstub));
      nstub    <= nstub + 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n && bus_oe)    n_oe    <= n_oe + 1;
    if (rst_n && adc_start) n_start <= n_start + 1;
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic issue(input int ch, input logic [2:0] card, output int c0);
    @(negedge clk);
    c0 = cyc;
    bus_req  = 1'b1;
    bus_addr = {card, 3'(ch)};
    @(negedge clk);
    bus_req = 1'b0;
  endtask

  task automatic wait_sig(input bit which_start, output int c);
    c = -1;
    for (int i = 0; i < 400; i++) begin
      if (which_start ? adc_start : bus_oe) begin
        c = cyc;
        break;
      end
      @(negedge clk);
    end
  endtask

  // exp_oe < 0: card idle, served at once; otherwise the expected bus_oe cycle.
  task automatic serve(input int ch, input int exp_oe);
    int c0, co, cs;
    issue(ch, CARD, c0);
    if (exp_oe >= 0) chk("R8 wait raised", int'(bus_wait), 1);
    wait_sig(1'b0, co);
    chk((exp_oe >= 0) ? "R6 served cycle" : "R2 oe cycle", co, (exp_oe >= 0) ? exp_oe : c0 + 1);
    chk("R2 returned word", int'(bus_rdata), int'(prev));
    chk("R3 mux at serve", int'(mux_sel), ch);
    chk("R8 wait dropped", int'(bus_wait), 0);
    @(negedge clk);
    chk("R2 oe one cycle", int'(bus_oe), 0);
    wait_sig(1'b1, cs);
    chk("R4 settle delay", cs - co, SET);
    chk("R3 mux at start", int'(mux_sel), ch);
    prev = 16'(code_of(ch, nserved) * 4);
    nserved++;
    last_start = cs;
  endtask

  initial begin
    int c0, co, cs, oe0, st0;
    repeat (4) @(negedge clk);
    chk("R9 oe in reset", int'(bus_oe), 0);
    chk("R9 wait in reset", int'(bus_wait), 0);
    chk("R9 start in reset", int'(adc_start), 0);
    chk("R9 mux in reset", int'(mux_sel), 0);
    rst_n = 1'b1;

    // R7: request during calibration, returns the reset latch value (R9).
    serve(1, CAL + 1);

    // R5/R6: back-to-back requests over every channel, each held behind the window.
    for (int i = 0; i < 8; i++) serve((i * 5 + 3) % 8, last_start + THRU);

    // Idle request served at once.
    repeat (THRU + 10) @(negedge clk);
    serve(6, -1);

    // R1: requests for every other card address are ignored.
    repeat (THRU + 10) @(negedge clk);
    oe0 = n_oe; st0 = n_start;
    for (int card = 0; card < 8; card++) begin
      if (3'(card) != CARD) begin
        issue(card, 3'(card), c0);
        chk("R1 no wait on miss", int'(bus_wait), 0);
      end
    end
    repeat (100) @(negedge clk);
    chk("R1 no oe on miss", n_oe - oe0, 0);
    chk("R1 no start on miss", n_start - st0, 0);
    serve(2, -1);

    // R8: second request while one is pending is dropped.
    issue(4, CARD, c0);
    issue(7, CARD, c0);
    oe0 = n_oe;
    wait_sig(1'b0, co);
    chk("R8 pending served", co, last_start + THRU);
    chk("R8 first kept", int'(mux_sel), 4);
    chk("R5 returned word", int'(bus_rdata), int'(prev));
    @(negedge clk);
    wait_sig(1'b1, cs);
    chk("R4 settle delay", cs - co, SET);
    prev = 16'(code_of(4, nserved) * 4);
    nserved++;
    last_start = cs;
    repeat (2 * THRU) @(negedge clk);
    chk("R8 extra dropped", n_oe - oe0, 1);
    chk("R8 wait idle", int'(bus_wait), 0);
    serve(0, -1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired act=1 exp=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule